// File: doc/BRIEF.md
# Board Control Register Block

A word-wide register block that gathers the small controls of a development board behind one memory-mapped window. It holds an eight-LED bar, an eight-character text display buffer, a general-purpose output byte, a break/reset byte, a soft-reset trigger and a group of software-driven I2C pin registers. Software writes the display buffer in one of two ways. It can write a whole word, which the block turns into eight uppercase hexadecimal digits. It can also write single characters, one position at a time.

The bus has a write port and an independent combinational read port, so one write and one read can happen in the same cycle. Only the low 20 address bits are decoded. A read returns the register state from before any write in the same cycle. The soft-reset output is a registered one-cycle pulse. The I2C pin registers drive the clock and data lines directly. The general-purpose input word reflects the I2C output register back to software.

Top module: `brdctl_regs`

## Requirements
- R1: Only address bits [19:0] are decoded; any value in the upper address bits aliases to the same register for reads and for writes.
- R2: Offsets 0x200 (switches) and 0x210 (jumpers) read 0 and ignore writes. Every offset not listed in R3 to R12 reads 0 and ignores writes. This includes 0x410, the character slots, 0x500, misaligned offsets such as 0x41C, and 0x458.
- R3: Offset 0x208 reads 0x12 when parameter BIG_ENDIAN is 1, and 0x10 when it is 0.
- R4: Offset 0x408 stores the low 8 bits of a write, drives them on `led_o`, reads them back zero-extended, and resets to 0.
- R5: A write to 0x410 replaces all eight display characters with the uppercase ASCII hex digits of the data ('0'-'9' are 0x30-0x39, 'A'-'F' are 0x41-0x46). Character 0 (`disp_o[7:0]`) gets data bits [31:28], and character k gets bits [31-4k:28-4k].
- R6: A write to offset 0x418 + 8k, for k = 0 to 7, stores the low data byte in character k (`disp_o[8k+7:8k]`) and leaves the other characters unchanged.
- R7: After reset all eight display characters hold 0x20.
- R8: A write of exactly 0x00000042 to 0x500 drives `sysrst_o` high for exactly the one cycle that follows the write edge. Any other value leaves `sysrst_o` low.
- R9: Offset 0x508 keeps 8 bits and resets to 0x0A, and is visible on `brk_o`. Offset 0xA00 keeps 8 bits and resets to 0, and is visible on `gpo_o`. Both read back zero-extended.
- R10: Offset 0xB08 keeps 2 bits, drives `i2c_oe_o` and resets to 0. Offset 0xB10 keeps the full 32-bit word and resets to 0x3; bit 1 drives `scl_o` and bit 0 drives `sda_o`. Offset 0xB18 keeps 1 bit and resets to 1.
- R11: Offset 0xA08 reads the full I2C output word when the select bit is 1, and reads 0 when it is 0.
- R12: Offset 0xB00 reads 0x2 with bit 0 replaced by the live `sda_in` level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write strobe, one write per cycle |
| wr_addr | input | ADDR_W | Write byte address |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | ADDR_W | Read byte address |
| rd_data | output | DATA_W | Combinational read data |
| sda_in | input | 1 | Live level of the I2C data line |
| led_o | output | 8 | LED bar |
| disp_o | output | NCHAR*8 | Display characters, character k at bits [8k+7:8k] |
| brk_o | output | 8 | Break/reset byte |
| gpo_o | output | 8 | General-purpose output byte |
| i2c_oe_o | output | 2 | I2C output enables |
| scl_o | output | 1 | I2C clock output level |
| sda_o | output | 1 | I2C data output level |
| sysrst_o | output | 1 | One-cycle soft-reset request |

## Verification
A write and a read can land in the same cycle, and the hardest pairing is a write that changes a register another offset reflects. Examples are a write to the I2C output or select register while 0xA08 is read, or a write to any register while that same register is read. The bench sets up these pairings directly, and also lets random traffic produce many of them. Each read is judged against a model in the bench that still holds the state from before the write. The write becomes visible only in the next cycle's read and on the outputs.

// File: rtl/brdctl_pkg.sv
package brdctl_pkg;

   localparam int OFF_W = 20;

   localparam logic [OFF_W-1:0] OFF_SWITCH = 20'h00200;
   localparam logic [OFF_W-1:0] OFF_STATUS = 20'h00208;
   localparam logic [OFF_W-1:0] OFF_JUMPER = 20'h00210;
   localparam logic [OFF_W-1:0] OFF_LEDBAR = 20'h00408;
   localparam logic [OFF_W-1:0] OFF_HEXWRD = 20'h00410;
   localparam logic [OFF_W-1:0] OFF_CHAR0  = 20'h00418;
   localparam logic [OFF_W-1:0] OFF_RSTKEY = 20'h00500;
   localparam logic [OFF_W-1:0] OFF_BRKBYT = 20'h00508;
   localparam logic [OFF_W-1:0] OFF_GPOUT  = 20'h00A00;
   localparam logic [OFF_W-1:0] OFF_GPIN   = 20'h00A08;
   localparam logic [OFF_W-1:0] OFF_I2CIN  = 20'h00B00;
   localparam logic [OFF_W-1:0] OFF_I2COE  = 20'h00B08;
   localparam logic [OFF_W-1:0] OFF_I2COUT = 20'h00B10;
   localparam logic [OFF_W-1:0] OFF_I2CSEL = 20'h00B18;

   localparam logic [7:0] RESET_KEY  = 8'h42;
   localparam logic [7:0] BRK_RST    = 8'h0A;
   localparam logic [7:0] BLANK_CHAR = 8'h20;
   localparam logic [31:0] I2CIN_HELD = 32'h3;

   function automatic logic [7:0] hex_ascii(input logic [3:0] nib);
      if (nib < 4'd10) return 8'h30 + {4'h0, nib};
      else             return 8'h37 + {4'h0, nib};
   endfunction

endpackage

// File: rtl/brdctl_field.sv
module brdctl_field #(
   parameter int          W   = 8,
   parameter logic [W-1:0] RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         we,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= RST;
      else if (we) q <= d;
   end
endmodule

// File: rtl/brdctl_dispbuf.sv
module brdctl_dispbuf
   import brdctl_pkg::*;
#(
   parameter int NCHAR  = 8,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(NCHAR)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               word_we,
   input  logic               char_we,
   input  logic [IDX_W-1:0]   char_idx,
   input  logic [DATA_W-1:0]  wdata,
   output logic [NCHAR*8-1:0] chars
);
   initial begin
      if (NCHAR * 4 != DATA_W) $fatal(1, "dispbuf: NCHAR*4 must equal DATA_W");
   end

   for (genvar k = 0; k < NCHAR; k++) begin : g_char
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            chars[8*k +: 8] <= BLANK_CHAR;
         else if (word_we)
            chars[8*k +: 8] <= hex_ascii(wdata[DATA_W-1-4*k -: 4]);
         else if (char_we && char_idx == IDX_W'(k))
            chars[8*k +: 8] <= wdata[7:0];
      end
   end

   // R5: leftmost character carries the top nibble after a word write
   p_word_msn_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $past(word_we) |-> chars[7:0] == hex_ascii($past(wdata[DATA_W-1 -: 4])));

   // R6: a single-character write lands its low byte in the addressed slot
   p_char_byte_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(char_we && !word_we && char_idx == '0) |-> chars[7:0] == $past(wdata[7:0]));
endmodule

// File: rtl/brdctl_regs.sv
module brdctl_regs
   import brdctl_pkg::*;
#(
   parameter int ADDR_W     = 32,
   parameter int DATA_W     = 32,
   parameter int NCHAR      = 8,
   parameter bit BIG_ENDIAN = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  wr_addr,
   input  logic [DATA_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0]  rd_addr,
   output logic [DATA_W-1:0]  rd_data,
   input  logic               sda_in,
   output logic [7:0]         led_o,
   output logic [NCHAR*8-1:0] disp_o,
   output logic [7:0]         brk_o,
   output logic [7:0]         gpo_o,
   output logic [1:0]         i2c_oe_o,
   output logic               scl_o,
   output logic               sda_o,
   output logic               sysrst_o
);
   localparam int IDX_W = $clog2(NCHAR);
   localparam logic [OFF_W-1:0] CHAR_LAST = OFF_CHAR0 + OFF_W'(8 * (NCHAR - 1));
   localparam logic [7:0] STATUS_VAL = BIG_ENDIAN ? 8'h12 : 8'h10;

   initial begin
      if (ADDR_W < OFF_W) $fatal(1, "brdctl_regs: ADDR_W below decode width");
      if (DATA_W != 32)   $fatal(1, "brdctl_regs: DATA_W must be 32");
      if (NCHAR < 2)      $fatal(1, "brdctl_regs: NCHAR must be at least 2");
   end

   logic [OFF_W-1:0] wr_off, rd_off, char_rel;
   logic             unused_upper;
   assign wr_off       = wr_addr[OFF_W-1:0];
   assign rd_off       = rd_addr[OFF_W-1:0];
   assign unused_upper = ^{wr_addr[ADDR_W-1:OFF_W], rd_addr[ADDR_W-1:OFF_W], char_rel[OFF_W-1:3+IDX_W], char_rel[2:0]};

   // write decode
   logic we_led, we_brk, we_gp, we_oe, we_out, we_sel, we_word, we_char, key_hit;
   assign we_led  = wr_en && wr_off == OFF_LEDBAR;
   assign we_brk  = wr_en && wr_off == OFF_BRKBYT;
   assign we_gp   = wr_en && wr_off == OFF_GPOUT;
   assign we_oe   = wr_en && wr_off == OFF_I2COE;
   assign we_out  = wr_en && wr_off == OFF_I2COUT;
   assign we_sel  = wr_en && wr_off == OFF_I2CSEL;
   assign we_word = wr_en && wr_off == OFF_HEXWRD;
   assign char_rel = wr_off - OFF_CHAR0;
   assign we_char = wr_en && wr_off >= OFF_CHAR0 && wr_off <= CHAR_LAST && wr_off[2:0] == 3'b000;
   assign key_hit = wr_en && wr_off == OFF_RSTKEY && wr_data == DATA_W'(RESET_KEY);

   logic [0:0]        sel_q;
   logic [DATA_W-1:0] out_q;

   brdctl_field #(.W(8), .RST(8'h00)) u_led (.clk, .rst_n, .we(we_led), .d(wr_data[7:0]), .q(led_o));
   brdctl_field #(.W(8), .RST(BRK_RST)) u_brk (.clk, .rst_n, .we(we_brk), .d(wr_data[7:0]), .q(brk_o));
   brdctl_field #(.W(8), .RST(8'h00)) u_gp  (.clk, .rst_n, .we(we_gp),  .d(wr_data[7:0]), .q(gpo_o));
   brdctl_field #(.W(2), .RST(2'b00)) u_oe  (.clk, .rst_n, .we(we_oe),  .d(wr_data[1:0]), .q(i2c_oe_o));
   brdctl_field #(.W(1), .RST(1'b1))  u_sel (.clk, .rst_n, .we(we_sel), .d(wr_data[0:0]), .q(sel_q));
   brdctl_field #(.W(DATA_W), .RST(DATA_W'(3))) u_out
      (.clk, .rst_n, .we(we_out), .d(wr_data), .q(out_q));

   assign scl_o = out_q[1];
   assign sda_o = out_q[0];

   brdctl_dispbuf #(.NCHAR(NCHAR), .DATA_W(DATA_W)) u_disp (
      .clk, .rst_n,
      .word_we (we_word),
      .char_we (we_char),
      .char_idx(char_rel[3 +: IDX_W]),
      .wdata   (wr_data),
      .chars   (disp_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sysrst_o <= 1'b0;
      else        sysrst_o <= key_hit;
   end

   // read mux
   always_comb begin
      rd_data = '0;
      case (rd_off)
         OFF_STATUS: rd_data = DATA_W'(STATUS_VAL);
         OFF_LEDBAR: rd_data = DATA_W'(led_o);
         OFF_BRKBYT: rd_data = DATA_W'(brk_o);
         OFF_GPOUT:  rd_data = DATA_W'(gpo_o);
         OFF_GPIN:   rd_data = sel_q[0] ? out_q : '0;
         OFF_I2CIN:  rd_data = {I2CIN_HELD[DATA_W-1:1], sda_in};
         OFF_I2COE:  rd_data = DATA_W'(i2c_oe_o);
         OFF_I2COUT: rd_data = out_q;
         OFF_I2CSEL: rd_data = DATA_W'(sel_q);
         default:    rd_data = '0;
      endcase
   end

   // R8: a pulse is only ever the echo of a key write one edge earlier
   p_pulse_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      sysrst_o |-> $past(wr_en && wr_off == OFF_RSTKEY && wr_data == DATA_W'(RESET_KEY)));

   // R4: LED bar follows the low byte of its last write
   p_led_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we_led) |-> led_o == $past(wr_data[7:0]));

   // R2: switch and jumper offsets never return data
   p_fixed_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_off == OFF_SWITCH || rd_off == OFF_JUMPER) |-> rd_data == '0);

   // R11: with select cleared the general input word is blank
   p_gpin_gate_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_off == OFF_GPIN && !sel_q[0]) |-> rd_data == '0);

   // R12: bit 0 of the I2C input word is the live data line
   p_sda_live_r12: assert property (@(posedge clk) disable iff (!rst_n)
      rd_off == OFF_I2CIN |-> rd_data[0] == sda_in);
endmodule

// File: tb/sim_brdctl_regs.sv
`timescale 1ns/1ps
module sim_brdctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [31:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
   logic [31:0] rd_data;
   logic        sda_in = 1'b0;
   logic [7:0]  led_o, brk_o, gpo_o;
   logic [63:0] disp_o;
   logic [1:0]  i2c_oe_o;
   logic        scl_o, sda_o, sysrst_o;

   always #4 clk = ~clk;

   brdctl_regs u0 (.clk, .rst_n, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data,
      .sda_in, .led_o, .disp_o, .brk_o, .gpo_o, .i2c_oe_o, .scl_o, .sda_o, .sysrst_o);

   int n_chk = 0, n_bad = 0;
   bit done = 0;

   // bench model
   logic [7:0]  m_led, m_brk, m_gp;
   logic [1:0]  m_oe;
   logic        m_sel, m_pulse;
   logic [31:0] m_out;
   logic [7:0]  m_ch [8];

   function automatic logic [7:0] hexc(input logic [3:0] n);
      return (n < 10) ? 8'(48 + n) : 8'(55 + n);
   endfunction

   function automatic logic [31:0] exp_rd(input logic [31:0] a, input logic s);
      case (a[19:0])
         20'h00208: return 32'h12;
         20'h00408: return {24'h0, m_led};
         20'h00508: return {24'h0, m_brk};
         20'h00A00: return {24'h0, m_gp};
         20'h00A08: return m_sel ? m_out : 32'h0;
         20'h00B00: return {31'h1, s};
         20'h00B08: return {30'h0, m_oe};
         20'h00B10: return m_out;
         20'h00B18: return {31'h0, m_sel};
         default:   return 32'h0;
      endcase
   endfunction

   function automatic string rd_tag(input logic [31:0] a);
      case (a[19:0])
         20'h00208: return "R3";
         20'h00408: return "R4";
         20'h00508, 20'h00A00: return "R9";
         20'h00A08: return "R11";
         20'h00B00: return "R12";
         20'h00B08, 20'h00B10, 20'h00B18: return "R10";
         default:   return "R2";
      endcase
   endfunction

   task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
      end
   endtask

   task automatic model_reset();
      m_led = 0; m_brk = 8'h0A; m_gp = 0; m_oe = 0; m_sel = 1; m_out = 32'h3; m_pulse = 0;
      for (int k = 0; k < 8; k++) m_ch[k] = 8'h20;
   endtask

   task automatic step(input logic we, input logic [31:0] wa, input logic [31:0] wd,
                       input logic [31:0] ra, input logic s);
      logic [63:0] dexp;
      logic [19:0] o;
      @(negedge clk);
      wr_en = we; wr_addr = wa; wr_data = wd; rd_addr = ra; sda_in = s;
      #1;
      for (int k = 0; k < 8; k++) dexp[8*k +: 8] = m_ch[k];
      chk(rd_tag(ra), {32'h0, rd_data}, {32'h0, exp_rd(ra, s)});   // read shows pre-write state
      chk("R8", {63'h0, sysrst_o}, {63'h0, m_pulse});
      chk("R4", {56'h0, led_o}, {56'h0, m_led});
      chk("R5/R6/R7", disp_o, dexp);
      chk("R9", {48'h0, brk_o, gpo_o}, {48'h0, m_brk, m_gp});
      chk("R10", {60'h0, i2c_oe_o, scl_o, sda_o}, {60'h0, m_oe, m_out[1:0]});
      // update model with this cycle's write
      o = wa[19:0];
      m_pulse = we && o == 20'h00500 && wd == 32'h42;
      if (we) begin
         case (o)
            20'h00408: m_led = wd[7:0];
            20'h00508: m_brk = wd[7:0];
            20'h00A00: m_gp  = wd[7:0];
            20'h00B08: m_oe  = wd[1:0];
            20'h00B10: m_out = wd;
            20'h00B18: m_sel = wd[0];
            20'h00410: for (int k = 0; k < 8; k++) m_ch[k] = hexc(wd[31-4*k -: 4]);
            default:
               if (o >= 20'h00418 && o <= 20'h00450 && o[2:0] == 0)
                  m_ch[(o - 20'h00418) >> 3] = wd[7:0];
         endcase
      end
   endtask

   logic [19:0] offs [24];
   initial begin
      offs = '{20'h00200, 20'h00208, 20'h00210, 20'h00408, 20'h00410, 20'h00418,
               20'h00420, 20'h00428, 20'h00430, 20'h00438, 20'h00440, 20'h00448,
               20'h00450, 20'h00500, 20'h00508, 20'h00A00, 20'h00A08, 20'h00B00,
               20'h00B08, 20'h00B10, 20'h00B18, 20'h00300, 20'h0041C, 20'h00458};
   end

   initial begin
      int unsigned sd;
      sd = $urandom(32'd20240611);
      model_reset();
      #21 rst_n = 1'b1;
      // R7 / R9 / R10 reset state and R3 status value
      step(0, 0, 0, 32'h208, 0);
      step(0, 0, 0, 32'hB18, 1);
      step(0, 0, 0, 32'hB10, 0);
      step(0, 0, 0, 32'hA08, 0);      // R11 select is 1 after reset
      // R8 magic value and near misses
      step(1, 32'h500, 32'h42, 32'h500, 0);
      step(1, 32'h500, 32'h43, 32'h0, 0);
      step(1, 32'h500, 32'h142, 32'h0, 0);
      step(1, 32'h500, 32'h42, 32'h0, 0);
      step(1, 32'h500, 32'h42, 32'h0, 0); // back-to-back keys
      step(0, 0, 0, 32'h0, 0);
      // R5 word write with letters and digits, then R6 single characters
      step(1, 32'h410, 32'h89ABCDEF, 32'h410, 0);
      step(1, 32'h418, 32'h7A, 32'h418, 0);
      step(1, 32'h450, 32'hFFFF_FF21, 32'h0, 0);
      step(1, 32'h41C, 32'h55, 32'h0, 0); // R2 misaligned slot ignored
      step(1, 32'h458, 32'h55, 32'h0, 0); // R2 past last slot ignored
      // R1 aliasing through upper address bits
      step(1, 32'hFFF00408, 32'h1234_56A5, 32'hABC00408, 0);
      step(0, 0, 0, 32'h00100408, 0);
      // R2 writes to fixed offsets have no effect
      step(1, 32'h200, 32'hFFFFFFFF, 32'h200, 0);
      step(1, 32'h210, 32'hFFFFFFFF, 32'h210, 0);
      // R11 with select cleared, write of I2C output while GPIN is read
      step(1, 32'hB18, 32'hFFFFFFFE, 32'hA08, 0);
      step(1, 32'hB10, 32'hDEAD_BEEF, 32'hA08, 1);
      step(1, 32'hB18, 32'h1, 32'hA08, 1);
      step(0, 0, 0, 32'hA08, 1);
      // R12 live data line
      step(0, 0, 0, 32'hB00, 1);
      step(0, 0, 0, 32'hB00, 0);
      // random traffic
      for (int i = 0; i < 4000; i++) begin
         logic [31:0] wa, ra, wd;
         wa = {$urandom() >> 20, offs[$urandom_range(0, 23)]};
         ra = {$urandom() >> 20, offs[$urandom_range(0, 23)]};
         if ($urandom_range(0, 3) == 0) ra = wa;
         wd = ($urandom_range(0, 7) == 0) ? 32'h42 : $urandom();
         step($urandom_range(0, 4) != 0, wa, wd, ra, 1'($urandom()));
      end
      step(0, 0, 0, 0, 0);
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      #(8 * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got hung expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule